// File: doc/BRIEF.md
# I2C Master Receive Byte Path

This block sits between the bit-level engine of an I2C master and the software-visible data register. Each byte the engine clocks in from the bus arrives as a one-cycle strobe with its data. The block stores it in a small first-in first-out buffer and decrements a programmable count of bytes still expected. It also tells the engine, ahead of each byte, whether that byte should be acknowledged or answered with a NACK that ends the read.

Software programs the count before a read starts and can reload it later to lengthen the transfer. It drains bytes through a pop strobe and can flush the buffer at any time. A level-sensitive hold control asks the engine to stretch the clock whenever the buffer is full, so that no byte is lost while software catches up. One-cycle event pulses report when the buffer nears full, when the programmed transfer completes, and when bytes are lost or a read finds the buffer empty.

Top module: `i2c_rx_byte_path`

## Requirements
- R1: The buffer holds up to 16 bytes, returns them on `rd_byte` in arrival order, and drives `rx_avail` high exactly while it holds at least one byte.
- R2: A `data_rd` pulse removes the oldest byte. When the buffer is empty, a `data_rd` pulse changes nothing except that `ev_rx_unf` pulses for one cycle on the next clock, and `rd_byte` reads 0 while the buffer is empty.
- R3: A byte that arrives while the buffer holds 16 bytes, with no pop in the same cycle, is discarded and `ev_rx_ovf` pulses for one cycle on the next clock.
- R4: `ev_data` pulses for one cycle when an accepted byte raises the buffer level from 13 to 14, which is two short of full.
- R5: A `size_we` pulse loads `size_wdata` (0 to 255) into the remaining count, and `size_remain` shows that count on the next clock. Each byte strobe that arrives while the count is nonzero lowers it by one.
- R6: `ack_out` is high only while the remaining count is 2 or more. The byte that arrives while the count is 1 therefore gets a NACK whatever the state of `hold_en`.
- R7: `ev_comp` pulses for one cycle on the clock after the byte that takes the count from 1 to 0.
- R8: `stall_req` is high while `hold_en` is set, the buffer is full and the count is nonzero. It drops on the clock after a pop frees an entry.
- R9: A `fifo_clr` pulse empties the buffer on the next clock. A pop in the same cycle is ignored and raises no underflow.
- R10: A byte strobe that arrives while the count is zero is ignored: nothing is stored, the count stays at zero and no event fires.
- R11: A reload of the count during a hold stall extends the transfer, and bytes after the reload are acknowledged until the new count runs down to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_strobe | input | 1 | One-cycle pulse: a byte was clocked in from the bus |
| rx_byte | input | 8 | Byte that goes with `rx_strobe` |
| size_we | input | 1 | Load the remaining count |
| size_wdata | input | 8 | Count value to load |
| hold_en | input | 1 | Stretch the bus clock while the buffer is full |
| fifo_clr | input | 1 | Empty the buffer |
| data_rd | input | 1 | Pop the oldest byte |
| rd_byte | output | 8 | Oldest stored byte, or 0 when empty |
| rx_avail | output | 1 | Buffer holds at least one byte |
| size_remain | output | 8 | Bytes still expected in the transfer |
| ack_out | output | 1 | 1: acknowledge the next byte, 0: NACK it |
| stall_req | output | 1 | Ask the engine to hold the bus clock low |
| ev_data | output | 1 | Buffer reached the near-full mark |
| ev_comp | output | 1 | Programmed transfer finished |
| ev_rx_ovf | output | 1 | Byte lost because the buffer was full |
| ev_rx_unf | output | 1 | Pop attempted on an empty buffer |

## Verification
The properties assume that the bus engine never sends a byte while `stall_req` is high. Without that, a hold stall could still end in an overflow, and the stall property would describe a request the engine did not honour. The stimulus keeps to this rule: in the hold-set scenarios it offers a byte only while the stall request is low. The one scenario that deliberately overflows the buffer runs with hold clear. The properties also take no position on a count reload that coincides with a byte strobe, and the stimulus never issues both in the same cycle.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    // One-cycle notifications produced by the receive byte path.
    typedef struct packed {
        logic near_full;
        logic done;
        logic lost;
        logic empty_read;
    } rx_evt_t;

endpackage

// File: rtl/i2c_rx_store.sv
module i2c_rx_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic                              push,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              pop,
    output logic [DATA_W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]        level,
    output logic                              full,
    output logic                              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [LVL_W-1:0]             lvl;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.lvl    = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wr_ptr] = wdata;
                st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
            end
            if (pop) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            st_d.lvl = st_q.lvl + LVL_W'(push) - LVL_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty = (st_q.lvl == '0);
    assign full  = (st_q.lvl == LVL_W'(DEPTH));
    assign level = st_q.lvl;
    assign rdata = empty ? '0 : st_q.mem[st_q.rd_ptr];

endmodule

// File: rtl/i2c_rx_count.sv
module i2c_rx_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remain,
    output logic             nonzero,
    output logic             at_last
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.cnt = load_val;
        end else if (dec && (c_q.cnt != '0)) begin
            c_d.cnt = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign remain  = c_q.cnt;
    assign nonzero = (c_q.cnt != '0);
    assign at_last = (c_q.cnt == CNT_W'(1));

endmodule

// File: rtl/i2c_rx_events.sv
module i2c_rx_events
    import i2c_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rx_evt_t raise,
    output rx_evt_t evt
);
    typedef struct packed {
        rx_evt_t pulse;
    } evt_state_t;

    evt_state_t e_d, e_q;

    always_comb begin
        e_d       = e_q;
        e_d.pulse = raise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign evt = e_q.pulse;

endmodule

// File: rtl/i2c_rx_byte_path.sv
module i2c_rx_byte_path
    import i2c_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int DATA_MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              size_we,
    input  logic [CNT_W-1:0]  size_wdata,
    input  logic              hold_en,
    input  logic              fifo_clr,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rx_avail,
    output logic [CNT_W-1:0]  size_remain,
    output logic              ack_out,
    output logic              stall_req,
    output logic              ev_data,
    output logic              ev_comp,
    output logic              ev_rx_ovf,
    output logic              ev_rx_unf
);
    localparam int LVL_W     = $clog2(DEPTH + 1);
    localparam int DATA_MARK = DEPTH - DATA_MARGIN;

    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full;
    logic             fifo_empty;
    logic             cnt_nz;
    logic             cnt_last;
    logic             take;
    logic             pop_ok;
    logic             push_ok;
    rx_evt_t          raise;
    rx_evt_t          evt;

    // A strobe only counts while a transfer is programmed; flush wins
    // over both store and pop in the same cycle.
    always_comb begin
        take    = rx_strobe && cnt_nz;
        pop_ok  = data_rd && !fifo_empty && !fifo_clr;
        push_ok = take && !fifo_clr && (!fifo_full || pop_ok);

        raise            = '0;
        raise.near_full  = push_ok && !pop_ok &&
                           (fifo_level == LVL_W'(DATA_MARK - 1));
        raise.done       = take && cnt_last && !size_we;
        raise.lost       = take && !fifo_clr && fifo_full && !pop_ok;
        raise.empty_read = data_rd && fifo_empty && !fifo_clr;
    end

    i2c_rx_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_clr),
        .push  (push_ok),
        .wdata (rx_byte),
        .pop   (pop_ok),
        .rdata (rd_byte),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    i2c_rx_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (size_we),
        .load_val (size_wdata),
        .dec      (take),
        .remain   (size_remain),
        .nonzero  (cnt_nz),
        .at_last  (cnt_last)
    );

    i2c_rx_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .evt   (evt)
    );

    assign rx_avail  = !fifo_empty;
    assign ack_out   = cnt_nz && !cnt_last;
    assign stall_req = hold_en && fifo_full && cnt_nz;
    assign ev_data   = evt.near_full;
    assign ev_comp   = evt.done;
    assign ev_rx_ovf = evt.lost;
    assign ev_rx_unf = evt.empty_read;

endmodule

// File: rtl/i2c_rx_byte_path_chk.sv
module i2c_rx_byte_path_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_strobe,
    input logic                       size_we,
    input logic [CNT_W-1:0]           size_wdata,
    input logic                       hold_en,
    input logic                       fifo_clr,
    input logic                       data_rd,
    input logic                       rx_avail,
    input logic [CNT_W-1:0]           size_remain,
    input logic                       ack_out,
    input logic                       stall_req,
    input logic                       ev_data,
    input logic                       ev_comp,
    input logic                       ev_rx_ovf,
    input logic                       ev_rx_unf,
    input logic                       fifo_full,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_avail && !fifo_clr) |=> ev_rx_unf);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && fifo_full && !data_rd && !fifo_clr && size_remain != '0)
        |=> (ev_rx_ovf && fifo_full));

    p_near_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data |-> (fifo_level == LVL_W'(DEPTH - 2)));

    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !size_we && size_remain != '0)
        |=> (size_remain == CNT_W'($past(size_remain) - 1'b1)));

    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        size_we |=> (size_remain == $past(size_wdata)));

    p_nack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !ack_out && !size_we && size_remain != '0)
        |=> (size_remain == '0 && ev_comp));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_comp |=> !ev_comp);

    p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> (hold_en && fifo_full));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!rx_avail && !ev_rx_unf));

    p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (size_remain == '0 && !size_we) |=> (size_remain == '0 && !ev_comp));

endmodule

bind i2c_rx_byte_path i2c_rx_byte_path_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_strobe   (rx_strobe),
    .size_we     (size_we),
    .size_wdata  (size_wdata),
    .hold_en     (hold_en),
    .fifo_clr    (fifo_clr),
    .data_rd     (data_rd),
    .rx_avail    (rx_avail),
    .size_remain (size_remain),
    .ack_out     (ack_out),
    .stall_req   (stall_req),
    .ev_data     (ev_data),
    .ev_comp     (ev_comp),
    .ev_rx_ovf   (ev_rx_ovf),
    .ev_rx_unf   (ev_rx_unf),
    .fifo_full   (fifo_full),
    .fifo_level  (fifo_level)
);

// File: tb/i2c_rx_byte_path_test.sv
`timescale 1ns/1ps
module i2c_rx_byte_path_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       size_we = 1'b0;
    logic [7:0] size_wdata = '0;
    logic       hold_en = 1'b0;
    logic       fifo_clr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rd_byte;
    logic       rx_avail;
    logic [7:0] size_remain;
    logic       ack_out;
    logic       stall_req;
    logic       ev_data;
    logic       ev_comp;
    logic       ev_rx_ovf;
    logic       ev_rx_unf;

    always #5 clk = ~clk;

    i2c_rx_byte_path uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_strobe   (rx_strobe),
        .rx_byte     (rx_byte),
        .size_we     (size_we),
        .size_wdata  (size_wdata),
        .hold_en     (hold_en),
        .fifo_clr    (fifo_clr),
        .data_rd     (data_rd),
        .rd_byte     (rd_byte),
        .rx_avail    (rx_avail),
        .size_remain (size_remain),
        .ack_out     (ack_out),
        .stall_req   (stall_req),
        .ev_data     (ev_data),
        .ev_comp     (ev_comp),
        .ev_rx_ovf   (ev_rx_ovf),
        .ev_rx_unf   (ev_rx_unf)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Behavioural reference state.
    byte unsigned m_q[$];
    int           m_cnt = 0;
    bit           m_data, m_comp, m_ovf, m_unf;
    byte unsigned got[$];
    byte unsigned sent[$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int  sz;
        bit  take, pop_ok;
        sz     = m_q.size();
        take   = rx_strobe && (m_cnt > 0);
        pop_ok = data_rd && (sz > 0) && !fifo_clr;
        m_data = 0; m_comp = 0; m_ovf = 0; m_unf = 0;
        m_unf  = data_rd && (sz == 0) && !fifo_clr;
        if (fifo_clr) begin
            m_q.delete();
        end else begin
            if (pop_ok) void'(m_q.pop_front());
            if (take) begin
                if (sz < 16 || pop_ok) begin
                    m_q.push_back(rx_byte);
                    if (!pop_ok && sz == 13) m_data = 1;
                end else begin
                    m_ovf = 1;
                end
            end
        end
        if (size_we) begin
            m_cnt = size_wdata;
        end else if (take) begin
            if (m_cnt == 1) m_comp = 1;
            m_cnt--;
        end
    endtask

    task automatic compare();
        chk("R1 avail", rx_avail, m_q.size() > 0);
        chk("R1 data", rd_byte, (m_q.size() > 0) ? m_q[0] : 0);
        chk("R5 remain", size_remain, m_cnt);
        chk("R6 ack", ack_out, m_cnt > 1);
        chk("R8 stall", stall_req, hold_en && m_q.size() == 16 && m_cnt > 0);
        chk("R4 ev_data", ev_data, m_data);
        chk("R7 ev_comp", ev_comp, m_comp);
        chk("R3 ev_ovf", ev_rx_ovf, m_ovf);
        chk("R2 ev_unf", ev_rx_unf, m_unf);
    endtask

    // Drive at the falling edge, step the model at the rising edge,
    // then compare at the next falling edge.
    task automatic cyc(input bit bv, input byte unsigned bd, input bit sw,
                       input byte unsigned swd, input bit clr, input bit rd);
        rx_strobe  = bv;
        rx_byte    = bd;
        size_we    = sw;
        size_wdata = swd;
        fifo_clr   = clr;
        data_rd    = rd;
        if (rd && rx_avail && !clr) got.push_back(rd_byte);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R1 reset avail", rx_avail, 0);
        chk("R5 reset remain", size_remain, 0);
        chk("R6 reset ack", ack_out, 0);
        chk("R8 reset stall", stall_req, 0);

        // R2: pop on empty buffer
        cyc(0, 0, 0, 0, 0, 1);
        chk("R2 underflow pulse", ev_rx_unf, 1);
        chk("R2 empty reads zero", rd_byte, 0);
        idle();
        chk("R2 underflow one cycle", ev_rx_unf, 0);

        // R10: strobe with count zero is ignored
        cyc(1, 8'h5A, 0, 0, 0, 0);
        chk("R10 nothing stored", rx_avail, 0);
        chk("R10 count stays zero", size_remain, 0);
        chk("R10 no completion", ev_comp, 0);

        // Short transfer, order and NACK of last byte (R1, R6, R7)
        cyc(0, 0, 1, 3, 0, 0);
        chk("R5 load", size_remain, 3);
        cyc(1, 8'h11, 0, 0, 0, 0);
        cyc(1, 8'h22, 0, 0, 0, 0);
        chk("R6 last byte gets NACK", ack_out, 0);
        cyc(1, 8'h33, 0, 0, 0, 0);
        chk("R7 completion", ev_comp, 1);
        got.delete();
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1);
        chk("R1 order b0", got[0], 8'h11);
        chk("R1 order b2", got[2], 8'h33);

        // 40-byte held transfer with a reload during the stall
        hold_en = 1'b1;
        got.delete();
        sent.delete();
        cyc(0, 0, 1, 20, 0, 0);
        for (int i = 0; i < 16; i++) begin
            sent.push_back(byte'(8'h40 + i));
            cyc(1, byte'(8'h40 + i), 0, 0, 0, 0);
            if (i == 13) chk("R4 near-full at 14", ev_data, 1);
        end
        chk("R8 stall when full", stall_req, 1);
        chk("R6 ack with count 4", ack_out, 1);
        cyc(0, 0, 1, 24, 0, 0);
        chk("R11 reload during stall", size_remain, 24);
        chk("R8 stall held", stall_req, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R8 release after pop", stall_req, 0);
        begin
            int k;
            k = 0;
            while ((sent.size() < 40 || rx_avail) && k < 400) begin
                bit bv, rd;
                byte unsigned bd;
                bv = (sent.size() < 40) && !stall_req;
                rd = rx_avail && (k % 2 == 0);
                bd = byte'(8'h40 + sent.size());
                if (bv && sent.size() == 39) begin
                    chk("R6 NACK final byte with hold set", ack_out, 0);
                end
                if (bv && sent.size() < 39) begin
                    chk("R11 ack after reload", ack_out, 1);
                end
                if (bv) sent.push_back(bd);
                cyc(bv, bd, 0, 0, 0, rd);
                if (bv && sent.size() == 40) chk("R7 completion after 40", ev_comp, 1);
                k++;
            end
        end
        chk("R1 all 40 read", got.size(), 40);
        for (int i = 0; i < 40; i++) begin
            if (i < got.size()) chk("R1 held order", got[i], sent[i]);
        end
        hold_en = 1'b0;

        // R3 overflow with hold clear, then R9 clear
        cyc(0, 0, 1, 20, 0, 0);
        for (int i = 0; i < 17; i++) cyc(1, byte'(8'h80 + i), 0, 0, 0, 0);
        chk("R3 overflow pulse", ev_rx_ovf, 1);
        chk("R8 no stall without hold", stall_req, 0);
        chk("R3 oldest kept", rd_byte, 8'h80);
        cyc(0, 0, 0, 0, 1, 1);
        chk("R9 cleared", rx_avail, 0);
        chk("R9 no underflow", ev_rx_unf, 0);
        chk("R9 count kept", size_remain, 3);
        for (int i = 0; i < 3; i++) cyc(1, byte'(8'hC0 + i), 0, 0, 0, 0);
        chk("R7 completion after clear", ev_comp, 1);
        cyc(1, 8'hEE, 0, 0, 0, 0);
        chk("R10 extra byte ignored", size_remain, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1);
        chk("R10 nothing after drain", rx_avail, 0);
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule